// File: doc/BRIEF.md
# DMA Tag-Group Completion Tracker

This block keeps one outstanding-command counter for each of 32 tag groups. The command queue reports each command it accepts on an enqueue strobe and each command it retires on a completion strobe, and both strobes carry the command's tag. A tag group counts as idle when its counter is zero. Software sets a persistent selection mask. Each bit of the mask picks one group.

A status read returns the idle vector of all groups ANDed with the mask. A read can use one of three modes. The immediate mode answers at once. The any mode holds off until at least one selected group is idle. The all mode holds off until every selected group is idle. While a waiting read is pending, the block raises a stall output. When the condition is met, it delivers the result as a one-cycle valid pulse. The processor uses the wait modes to block on DMA completion without polling.

Top module: `tgs_tag_status`

## Requirements
- R1: After reset every counter is zero, the mask is all zeros, and `rd_valid` and `rd_stall` are low.
- R2: A tag's counter rises by one on an enqueue for that tag and falls by one on a completion for it. An enqueue and a completion for the same tag in the same cycle leave the counter unchanged. A tag shows idle only when its counter is back at zero.
- R3: A mask write loads `mask_wdata`, where bit n selects tag group n. The mask keeps that value until the next write.
- R4: A read with `rd_mode` 0 is answered in the cycle after the request, without stalling. `rd_data` bit n is 1 exactly when tag n has no outstanding command and mask bit n is 1.
- R5: A read with `rd_mode` 1 is answered only once at least one selected group is idle. The data is the masked idle vector.
- R6: A read with `rd_mode` 2 is answered only once every selected group is idle. The data then equals the mask.
- R7: With an all-zero mask, reads in mode 1 and mode 2 are answered in the next cycle with data zero.
- R8: From the cycle after a waiting read is accepted until its answer, `rd_stall` is high and `rd_valid` is low. A `rd_req` made while stalled is ignored. The answer appears in the cycle after the condition first holds in the counters.
- R9: `rd_mode` 3 behaves like mode 0.
- R10: A completion for a tag whose counter is zero is ignored.
- R11: A read sees the counters and mask as they stood before the clock edge that accepts it. An enqueue in the same cycle is not reflected in the answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A command with tag `enq_tag` entered the queue |
| enq_tag | input | 5 | Tag of the entering command |
| cpl_valid | input | 1 | A command with tag `cpl_tag` finished |
| cpl_tag | input | 5 | Tag of the finished command |
| mask_wr | input | 1 | Load the selection mask |
| mask_wdata | input | 32 | New selection mask, bit n selects tag n |
| rd_req | input | 1 | Status read request |
| rd_mode | input | 2 | 0/3 immediate, 1 wait-any, 2 wait-all |
| rd_valid | output | 1 | One-cycle pulse: read answered |
| rd_data | output | 32 | Masked idle vector of the last answer |
| rd_stall | output | 1 | A waiting read is pending |

## Verification
Random-looking enqueue and completion sequences are replayed from a table. Each step is followed by an immediate read, which separates correct increment, decrement, same-tag collision and zero-count completion from counter drift. Wait reads are issued against groups that retire in a chosen order. This tells the any condition from the all condition, and it pins the answer latency to the cycle after the last needed completion. Zero-mask reads, mode 3, and a read coinciding with an enqueue check the corners where a tracker might hang or report post-edge state.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    typedef enum logic [1:0] {
        RD_NOW     = 2'd0,
        RD_ANY     = 2'd1,
        RD_ALL     = 2'd2,
        RD_NOW_ALT = 2'd3
    } rd_mode_e;

endpackage

// File: rtl/tgs_tag_counter.sv
module tgs_tag_counter #(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic idle
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc, dec})
            2'b10: st_d.cnt = st_q.cnt + 1'b1;
            2'b01: if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle = (st_q.cnt == '0);

endmodule

// File: rtl/tgs_mask_reg.sv
module tgs_mask_reg #(
    parameter int NUM_TAGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [NUM_TAGS-1:0] wdata,
    output logic [NUM_TAGS-1:0] mask
);

    typedef struct packed {
        logic [NUM_TAGS-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.mask;

endmodule

// File: rtl/tgs_read_ctrl.sv
module tgs_read_ctrl
    import tgs_pkg::*;
#(
    parameter int NUM_TAGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAGS-1:0] idle_vec,
    input  logic [NUM_TAGS-1:0] mask,
    input  logic                rd_req,
    input  logic [1:0]          rd_mode,
    output logic                rd_valid,
    output logic [NUM_TAGS-1:0] rd_data,
    output logic                rd_stall
);

    typedef struct packed {
        logic                waiting;
        logic                want_all;
        logic                valid;
        logic [NUM_TAGS-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    logic [NUM_TAGS-1:0] masked;
    logic                any_ok;
    logic                all_ok;

    assign masked = idle_vec & mask;
    assign any_ok = (masked != '0) || (mask == '0);
    assign all_ok = (masked == mask);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (st_q.waiting) begin
            if (st_q.want_all ? all_ok : any_ok) begin
                st_d.waiting = 1'b0;
                st_d.valid   = 1'b1;
                st_d.data    = masked;
            end
        end else if (rd_req) begin
            unique case (rd_mode_e'(rd_mode))
                RD_ANY: begin
                    if (any_ok) begin
                        st_d.valid = 1'b1;
                        st_d.data  = masked;
                    end else begin
                        st_d.waiting  = 1'b1;
                        st_d.want_all = 1'b0;
                    end
                end
                RD_ALL: begin
                    if (all_ok) begin
                        st_d.valid = 1'b1;
                        st_d.data  = masked;
                    end else begin
                        st_d.waiting  = 1'b1;
                        st_d.want_all = 1'b1;
                    end
                end
                default: begin
                    st_d.valid = 1'b1;
                    st_d.data  = masked;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;
    assign rd_stall = st_q.waiting;

endmodule

// File: rtl/tgs_tag_status.sv
module tgs_tag_status #(
    parameter int NUM_TAGS        = 32,
    parameter int MAX_OUTSTANDING = 16,
    localparam int TAG_W          = $clog2(NUM_TAGS),
    localparam int CNT_W          = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enq_valid,
    input  logic [TAG_W-1:0]    enq_tag,
    input  logic                cpl_valid,
    input  logic [TAG_W-1:0]    cpl_tag,
    input  logic                mask_wr,
    input  logic [NUM_TAGS-1:0] mask_wdata,
    input  logic                rd_req,
    input  logic [1:0]          rd_mode,
    output logic                rd_valid,
    output logic [NUM_TAGS-1:0] rd_data,
    output logic                rd_stall
);

    logic [NUM_TAGS-1:0] idle_vec;
    logic [NUM_TAGS-1:0] mask_q;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        logic inc;
        logic dec;
        assign inc = enq_valid && (enq_tag == TAG_W'(t));
        assign dec = cpl_valid && (cpl_tag == TAG_W'(t));
        tgs_tag_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc),
            .dec  (dec),
            .idle (idle_vec[t])
        );
    end

    tgs_mask_reg #(.NUM_TAGS(NUM_TAGS)) u_mask (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (mask_wr),
        .wdata(mask_wdata),
        .mask (mask_q)
    );

    tgs_read_ctrl #(.NUM_TAGS(NUM_TAGS)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle_vec(idle_vec),
        .mask    (mask_q),
        .rd_req  (rd_req),
        .rd_mode (rd_mode),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .rd_stall(rd_stall)
    );

endmodule

// File: rtl/tgs_tag_status_chk.sv
module tgs_tag_status_chk #(
    parameter int NUM_TAGS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_req,
    input logic [1:0]          rd_mode,
    input logic                mask_wr,
    input logic [NUM_TAGS-1:0] mask_q,
    input logic                rd_valid,
    input logic [NUM_TAGS-1:0] rd_data,
    input logic                rd_stall
);

    logic last_any_q;
    logic last_all_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_any_q <= 1'b0;
            last_all_q <= 1'b0;
        end else if (rd_req && !rd_stall) begin
            last_any_q <= (rd_mode == 2'd1);
            last_all_q <= (rd_mode == 2'd2);
        end
    end

    // R8: stall and answer are never shown together
    a_r8_no_valid_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> !rd_valid);

    // R4 and R9: immediate reads answer on the next cycle
    a_r4_immediate_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_stall && (rd_mode == 2'd0 || rd_mode == 2'd3)) |=> rd_valid);

    // R7: empty mask never stalls and yields zero
    a_r7_zero_mask_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_stall && mask_q == '0) |=> (rd_valid && rd_data == '0));

    // R6: an all-mode answer covers the whole mask
    a_r6_all_equals_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && last_all_q) |-> (rd_data == $past(mask_q)));

    // R5: an any-mode answer with a non-empty mask shows an idle group
    a_r5_any_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && last_any_q && $past(mask_q) != '0) |-> (rd_data != '0));

    // R3: the mask changes only on a write
    a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

endmodule

bind tgs_tag_status tgs_tag_status_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_mode (rd_mode),
    .mask_wr (mask_wr),
    .mask_q  (mask_q),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_stall(rd_stall)
);

// File: tb/tgs_tag_status_tb.sv
module tgs_tag_status_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enq_valid;
    logic [4:0]  enq_tag;
    logic        cpl_valid;
    logic [4:0]  cpl_tag;
    logic        mask_wr;
    logic [31:0] mask_wdata;
    logic        rd_req;
    logic [1:0]  rd_mode;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_stall;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int model_cnt [32];

    always #5 clk = ~clk;

    tgs_tag_status u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_tag(enq_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .rd_req(rd_req), .rd_mode(rd_mode),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_stall(rd_stall)
    );

    typedef struct packed {
        logic       ev;
        logic [4:0] et;
        logic       cv;
        logic [4:0] ct;
    } step_t;

    localparam int NSTEP = 10;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 5'd0,  1'b0, 5'd0},
        '{1'b1, 5'd0,  1'b0, 5'd0},
        '{1'b1, 5'd5,  1'b0, 5'd0},
        '{1'b1, 5'd31, 1'b1, 5'd0},
        '{1'b0, 5'd0,  1'b1, 5'd0},
        '{1'b1, 5'd5,  1'b1, 5'd5},
        '{1'b0, 5'd0,  1'b1, 5'd7},
        '{1'b0, 5'd0,  1'b1, 5'd5},
        '{1'b1, 5'd3,  1'b1, 5'd31},
        '{1'b0, 5'd0,  1'b1, 5'd3}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] model_idle();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = (model_cnt[i] == 0);
        return v;
    endfunction

    task automatic step(logic ev, logic [4:0] et, logic cv, logic [4:0] ct);
        enq_valid = ev; enq_tag = et; cpl_valid = cv; cpl_tag = ct;
        tick();
        enq_valid = 1'b0; cpl_valid = 1'b0;
        if (!(ev && cv && et == ct)) begin
            if (ev) model_cnt[et]++;
            if (cv && model_cnt[ct] > 0) model_cnt[ct]--;
        end
    endtask

    task automatic set_mask(logic [31:0] m);
        mask_wr = 1'b1; mask_wdata = m;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic issue(logic [1:0] mode);
        rd_req = 1'b1; rd_mode = mode;
        tick();
        rd_req = 1'b0;
    endtask

    task automatic read_now(string req, logic [1:0] mode, logic [31:0] exp);
        issue(mode);
        check({req, " valid"}, {31'd0, rd_valid}, 32'd1);
        check({req, " data"}, rd_data, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model_cnt[i] = 0;
        rst_n = 1'b0; enq_valid = 1'b0; enq_tag = '0; cpl_valid = 1'b0; cpl_tag = '0;
        mask_wr = 1'b0; mask_wdata = '0; rd_req = 1'b0; rd_mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 rd_stall", {31'd0, rd_stall}, 32'd0);
        read_now("R1 mask zero", 2'd0, 32'h0);
        set_mask(32'hFFFF_FFFF);
        read_now("R1 counters zero", 2'd0, 32'hFFFF_FFFF);

        // R2, R10: table of counter events, each followed by an immediate read
        for (int s = 0; s < NSTEP; s++) begin
            step(STEPS[s].ev, STEPS[s].et, STEPS[s].cv, STEPS[s].ct);
            read_now("R2 R10 table", 2'd0, model_idle());
        end

        // R2: depth of three on one tag
        step(1'b1, 5'd12, 1'b0, 5'd0);
        step(1'b1, 5'd12, 1'b0, 5'd0);
        step(1'b1, 5'd12, 1'b0, 5'd0);
        step(1'b0, 5'd0, 1'b1, 5'd12);
        step(1'b0, 5'd0, 1'b1, 5'd12);
        read_now("R2 still busy", 2'd0, ~(32'h1 << 12));
        step(1'b0, 5'd0, 1'b1, 5'd12);
        read_now("R2 drained", 2'd0, 32'hFFFF_FFFF);

        // R3: mask holds between writes
        set_mask(32'h0000_00F0);
        read_now("R3 mask applied", 2'd0, 32'h0000_00F0);
        step(1'b1, 5'd5, 1'b0, 5'd0);
        repeat (5) tick();
        read_now("R3 mask held", 2'd0, 32'h0000_00D0);
        step(1'b0, 5'd0, 1'b1, 5'd5);

        // R5, R8: any mode
        set_mask((32'h1 << 2) | (32'h1 << 9));
        step(1'b1, 5'd2, 1'b0, 5'd0);
        step(1'b1, 5'd9, 1'b0, 5'd0);
        issue(2'd1);
        check("R8 stall raised", {31'd0, rd_stall}, 32'd1);
        check("R8 no valid", {31'd0, rd_valid}, 32'd0);
        tick(); tick();
        check("R5 still waiting", {31'd0, rd_stall}, 32'd1);
        issue(2'd0);
        check("R8 request ignored valid", {31'd0, rd_valid}, 32'd0);
        check("R8 request ignored stall", {31'd0, rd_stall}, 32'd1);
        step(1'b0, 5'd0, 1'b1, 5'd9);
        check("R8 stall after completion edge", {31'd0, rd_stall}, 32'd1);
        check("R8 no early valid", {31'd0, rd_valid}, 32'd0);
        tick();
        check("R5 answer valid", {31'd0, rd_valid}, 32'd1);
        check("R5 answer data", rd_data, 32'h1 << 9);
        check("R8 stall released", {31'd0, rd_stall}, 32'd0);
        tick();
        check("R8 valid is a pulse", {31'd0, rd_valid}, 32'd0);

        // R6: all mode, tag 2 still outstanding
        set_mask((32'h1 << 2) | (32'h1 << 4));
        step(1'b1, 5'd4, 1'b0, 5'd0);
        issue(2'd2);
        check("R6 stall raised", {31'd0, rd_stall}, 32'd1);
        step(1'b0, 5'd0, 1'b1, 5'd2);
        tick();
        check("R6 one idle is not enough", {31'd0, rd_stall}, 32'd1);
        check("R6 no valid yet", {31'd0, rd_valid}, 32'd0);
        step(1'b0, 5'd0, 1'b1, 5'd4);
        check("R6 still stalled at edge", {31'd0, rd_stall}, 32'd1);
        tick();
        check("R6 answer valid", {31'd0, rd_valid}, 32'd1);
        check("R6 answer data", rd_data, (32'h1 << 2) | (32'h1 << 4));

        // R7: zero mask never stalls
        set_mask(32'h0);
        step(1'b1, 5'd8, 1'b0, 5'd0);
        read_now("R7 any zero mask", 2'd1, 32'h0);
        check("R7 any no stall", {31'd0, rd_stall}, 32'd0);
        read_now("R7 all zero mask", 2'd2, 32'h0);
        check("R7 all no stall", {31'd0, rd_stall}, 32'd0);
        step(1'b0, 5'd0, 1'b1, 5'd8);

        // R9: mode 3 acts as immediate
        set_mask(32'hFFFF_FFFF);
        step(1'b1, 5'd1, 1'b0, 5'd0);
        read_now("R9 mode 3", 2'd3, ~(32'h1 << 1));
        check("R9 no stall", {31'd0, rd_stall}, 32'd0);
        step(1'b0, 5'd0, 1'b1, 5'd1);

        // R11: read in the same cycle as an enqueue sees pre-edge counters
        enq_valid = 1'b1; enq_tag = 5'd6;
        rd_req = 1'b1; rd_mode = 2'd0;
        tick();
        enq_valid = 1'b0; rd_req = 1'b0;
        model_cnt[6]++;
        check("R11 pre-edge view", rd_data, 32'hFFFF_FFFF);
        read_now("R11 following read", 2'd0, ~(32'h1 << 6));
        step(1'b0, 5'd0, 1'b1, 5'd6);
        read_now("R4 all idle again", 2'd0, 32'hFFFF_FFFF);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule